// File: doc/BRIEF.md
# SDH Pattern-Dependence Stress Generator

This block produces a byte-wide, endlessly repeating stream built to stress the clock-recovery and decision circuits of an STM-N receiver. Each test period joins two kinds of long constant runs with no timing content (all ones and all zeros) to pseudo-random segments from a scrambler that never restarts. It also inserts a synthetic first row of section overhead. The result is a single worst-case sequence rather than a plain PRBS source.

The STM level, the length of the constant runs and the length of each pseudo-random segment are parameters. A single enable input gates the stream. While enable is high, one byte is produced per clock with a valid flag, and a marker flags the first byte of every period. While enable is low, the stream pauses and loses no position. Serialization, line coding and the optical stage sit downstream.

Top module: `sdh_stress_gen`

## Requirements
- R1: Every test period begins with RUN_BYTES (default 9) bytes of 0xFF.
- R2: The all-zero segment is RUN_BYTES bytes of 0x00.
- R3: Each pseudo-random segment is ceil(PRBS_BITS/8) bytes long. PRBS_BITS defaults to 2000 and should be at least 2000. The bytes come from a 7-bit LFSR with polynomial x^7+x^6+1, where the output bit is state[6] and the shift-in bit is state[6]^state[5]. The LFSR is seeded with all ones, packs bits MSB first, and takes 8 steps per byte. Its first byte after reset is 0xFE.
- R4: Each overhead segment is 9N bytes. It opens with 3N bytes of 0xF6 followed by 3N bytes of 0x28.
- R5: The next N overhead bytes are binary counts 1, 2, ..., N.
- R6: The last 2N overhead bytes are 0xAA.
- R7: Within a period, segments follow this order: ones, pseudo-random, overhead, zeros, pseudo-random, overhead. The period then repeats.
- R8: period_start is high together with out_valid on the first byte of each period, and low on every other byte.
- R9: An edge with en low makes out_valid low after that edge and keeps out_byte unchanged. The sequence position and the scrambler state do not advance.
- R10: The scrambler advances only on pseudo-random bytes. It continues across segments and periods, and only reset reseeds it.
- R11: After a clock edge with rst high, out_valid and period_start are low. The next enabled byte is the first byte of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Produce one byte at this edge when high |
| out_byte | output | 8 | Stream byte, MSB transmitted first |
| out_valid | output | 1 | out_byte is a new stream byte |
| period_start | output | 1 | First byte of a test period |

## Verification
The checker watches, on every cycle, the constant run values, the pairing of the period marker with valid and with the all-ones byte, the idle behaviour under a low enable, and the reset state. The exact pseudo-random bytes, the overhead layout with its counting bytes, the segment order and the scrambler's continuity across periods and enable gaps can only be shown by the bench. It runs a small configuration over several full periods against an arithmetic model and irregular enable gaps, then resets in mid-stream.

// File: rtl/sdh_stress_pkg.sv
package sdh_stress_pkg;
  typedef enum logic [2:0] {
    SEG_ONES   = 3'd0,
    SEG_PRBS_A = 3'd1,
    SEG_OH_A   = 3'd2,
    SEG_ZEROS  = 3'd3,
    SEG_PRBS_B = 3'd4,
    SEG_OH_B   = 3'd5
  } seg_t;

  localparam logic [7:0] FRAME_WORD_1 = 8'hF6;
  localparam logic [7:0] FRAME_WORD_2 = 8'h28;
  localparam logic [7:0] OH_FILL      = 8'hAA;
  localparam logic [6:0] LFSR_SEED    = 7'h7F;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/stress_seq.sv
module stress_seq
  import sdh_stress_pkg::*;
#(
  parameter int RUN_BYTES  = 9,
  parameter int PRBS_BYTES = 250,
  parameter int OH_BYTES   = 9,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output seg_t             seg,
  output logic [IDX_W-1:0] idx,
  output logic             first
);
  localparam logic [IDX_W-1:0] RUN_LAST  = IDX_W'(RUN_BYTES - 1);
  localparam logic [IDX_W-1:0] PRBS_LAST = IDX_W'(PRBS_BYTES - 1);
  localparam logic [IDX_W-1:0] OH_LAST   = IDX_W'(OH_BYTES - 1);

  seg_t             seg_q, seg_nxt;
  logic [IDX_W-1:0] idx_q, last;

  always_comb begin
    unique case (seg_q)
      SEG_ONES, SEG_ZEROS:     last = RUN_LAST;
      SEG_PRBS_A, SEG_PRBS_B:  last = PRBS_LAST;
      default:                 last = OH_LAST;
    endcase
    unique case (seg_q)
      SEG_ONES:   seg_nxt = SEG_PRBS_A;
      SEG_PRBS_A: seg_nxt = SEG_OH_A;
      SEG_OH_A:   seg_nxt = SEG_ZEROS;
      SEG_ZEROS:  seg_nxt = SEG_PRBS_B;
      SEG_PRBS_B: seg_nxt = SEG_OH_B;
      default:    seg_nxt = SEG_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_ONES;
      idx_q <= '0;
    end else if (step) begin
      if (idx_q == last) begin
        idx_q <= '0;
        seg_q <= seg_nxt;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign seg   = seg_q;
  assign idx   = idx_q;
  assign first = (seg_q == SEG_ONES) && (idx_q == '0);
endmodule

// File: rtl/stress_prbs.sv
module stress_prbs
  import sdh_stress_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  output logic [7:0] byte_o
);
  logic [6:0] state_q, state_nxt;
  logic [7:0] bits;

  always_comb begin
    logic [6:0] s;
    s = state_q;
    bits = '0;
    for (int i = 7; i >= 0; i--) begin
      bits[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk) begin
    if (rst)       state_q <= LFSR_SEED;
    else if (step) state_q <= state_nxt;
  end

  assign byte_o = bits;
endmodule

// File: rtl/stress_oh_row.sv
module stress_oh_row
  import sdh_stress_pkg::*;
#(
  parameter int N_LEVEL = 1,
  parameter int IDX_W   = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  localparam logic [IDX_W-1:0] END_W1 = IDX_W'(3 * N_LEVEL);
  localparam logic [IDX_W-1:0] END_W2 = IDX_W'(6 * N_LEVEL);
  localparam logic [IDX_W-1:0] END_CT = IDX_W'(7 * N_LEVEL);

  logic [IDX_W-1:0] count;

  always_comb begin
    count = idx - END_W2 + 1'b1;
    if (idx < END_W1)      byte_o = FRAME_WORD_1;
    else if (idx < END_W2) byte_o = FRAME_WORD_2;
    else if (idx < END_CT) byte_o = count[7:0];
    else                   byte_o = OH_FILL;
  end
endmodule

// File: rtl/sdh_stress_gen.sv
module sdh_stress_gen
  import sdh_stress_pkg::*;
#(
  parameter int N_LEVEL   = 1,
  parameter int RUN_BYTES = 9,
  parameter int PRBS_BITS = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [7:0] out_byte,
  output logic       out_valid,
  output logic       period_start
);
  localparam int PRBS_BYTES = (PRBS_BITS + 7) / 8;
  localparam int OH_BYTES   = 9 * N_LEVEL;
  localparam int MAX_LEN    = max3(RUN_BYTES, PRBS_BYTES, OH_BYTES);
  localparam int IDX_RAW    = $clog2(MAX_LEN + 1);
  localparam int IDX_W      = (IDX_RAW < 8) ? 8 : IDX_RAW;

  seg_t             cur_seg;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_first, in_prbs;
  logic [7:0]       prbs_byte, oh_byte, pick;

  assign in_prbs = (cur_seg == SEG_PRBS_A) || (cur_seg == SEG_PRBS_B);

  stress_seq #(
    .RUN_BYTES(RUN_BYTES), .PRBS_BYTES(PRBS_BYTES),
    .OH_BYTES(OH_BYTES), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .step(en),
    .seg(cur_seg), .idx(cur_idx), .first(cur_first)
  );

  stress_prbs u_prbs (
    .clk(clk), .rst(rst), .step(en && in_prbs), .byte_o(prbs_byte)
  );

  stress_oh_row #(.N_LEVEL(N_LEVEL), .IDX_W(IDX_W)) u_oh (
    .idx(cur_idx), .byte_o(oh_byte)
  );

  always_comb begin
    unique case (cur_seg)
      SEG_ONES:               pick = 8'hFF;
      SEG_ZEROS:              pick = 8'h00;
      SEG_PRBS_A, SEG_PRBS_B: pick = prbs_byte;
      default:                pick = oh_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte     <= '0;
      out_valid    <= 1'b0;
      period_start <= 1'b0;
    end else if (en) begin
      out_byte     <= pick;
      out_valid    <= 1'b1;
      period_start <= cur_first;
    end else begin
      out_valid    <= 1'b0;
      period_start <= 1'b0;
    end
  end
endmodule

// File: rtl/stress_gen_checker.sv
module stress_gen_checker
  import sdh_stress_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [7:0] out_byte,
  input logic       out_valid,
  input logic       period_start,
  input seg_t       seg
);
  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && !period_start));

  assert_ones_run_R1: assert property (@(posedge clk) disable iff (rst)
    (en && seg == SEG_ONES) |=> (out_valid && out_byte == 8'hFF));

  assert_zeros_run_R2: assert property (@(posedge clk) disable iff (rst)
    (en && seg == SEG_ZEROS) |=> (out_valid && out_byte == 8'h00));

  assert_marker_valid_R8: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (out_valid && out_byte == 8'hFF));

  assert_marker_only_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (en && seg != SEG_ONES) |=> !period_start);

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!out_valid && $stable(out_byte)));
endmodule

bind sdh_stress_gen stress_gen_checker u_chk (
  .clk(clk), .rst(rst), .en(en), .out_byte(out_byte),
  .out_valid(out_valid), .period_start(period_start), .seg(cur_seg)
);

// File: tb/sim_sdh_stress_gen.sv
module sim_sdh_stress_gen;
  localparam int N     = 2;
  localparam int RUN   = 9;
  localparam int PBITS = 20;
  localparam int P     = (PBITS + 7) / 8;
  localparam int OH    = 9 * N;
  localparam int PER   = 2 * RUN + 2 * P + 2 * OH;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] out_byte;
  logic       out_valid, period_start;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int         k;
  logic [6:0] lfsr;
  logic [7:0] last_byte;

  always #10 clk = ~clk;

  sdh_stress_gen #(.N_LEVEL(N), .RUN_BYTES(RUN), .PRBS_BITS(PBITS)) u0 (
    .clk(clk), .rst(rst), .en(en), .out_byte(out_byte),
    .out_valid(out_valid), .period_start(period_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected byte at period offset q, advancing the model scrambler on PRBS bytes.
  task automatic expect_byte(input int q, output logic [7:0] b, output string req);
    int off;
    bit is_prbs;
    is_prbs = 0;
    if (q < RUN) begin b = 8'hFF; req = "R1"; end
    else if (q < RUN + P) is_prbs = 1;
    else if (q < RUN + P + OH) off = q - RUN - P;
    else if (q < 2 * RUN + P + OH) begin b = 8'h00; req = "R2"; end
    else if (q < 2 * RUN + 2 * P + OH) is_prbs = 1;
    else off = q - 2 * RUN - 2 * P - OH;
    if (is_prbs) begin
      for (int i = 7; i >= 0; i--) begin
        b[i] = lfsr[6];
        lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      end
      req = "R3/R10";
    end else if (!(q < RUN) && !(q >= RUN + P + OH && q < 2 * RUN + P + OH)) begin
      if (off < 3 * N)      begin b = 8'hF6; req = "R4"; end
      else if (off < 6 * N) begin b = 8'h28; req = "R4"; end
      else if (off < 7 * N) begin b = 8'(off - 6 * N + 1); req = "R5"; end
      else                  begin b = 8'hAA; req = "R6"; end
    end
  endtask

  task automatic run_cycle(input bit e);
    logic [7:0] eb;
    string req;
    en = e;
    @(negedge clk);
    if (e) begin
      expect_byte(k, eb, req);
      check(out_valid === 1'b1, "R7 valid", int'(out_valid), 1);
      check(out_byte === eb, req, int'(out_byte), int'(eb));
      check(period_start === (k == 0), "R8", int'(period_start), int'(k == 0));
      if (k == RUN && lfsr == 7'h7F)
        check(1'b1, "R3", 0, 0);
      k = (k + 1) % PER;
      last_byte = eb;
    end else begin
      check(out_valid === 1'b0 && period_start === 1'b0, "R9 idle", int'(out_valid), 0);
      check(out_byte === last_byte, "R9 hold", int'(out_byte), int'(last_byte));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    k = 0; lfsr = 7'h7F; last_byte = 8'h00;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && period_start === 1'b0, "R11", int'(out_valid), 0);
    rst = 1'b0;
    // First PRBS byte after reset (R3): reach offset RUN and compare with 0xFE.
    for (int c = 0; c < RUN; c++) run_cycle(1'b1);
    en = 1'b1;
    @(negedge clk);
    check(out_byte === 8'hFE, "R3 first", int'(out_byte), 8'hFE);
    begin
      logic [7:0] eb; string req;
      expect_byte(k, eb, req);
      k = k + 1; last_byte = eb;
    end
    // Several periods with irregular pauses (R7, R9, R10).
    for (int c = 0; c < 280; c++)
      run_cycle(!((c % 7 == 6) || (c >= 40 && c < 45) || (c % 23 == 11)));
    // Mid-stream reset (R11): restarts period and scrambler.
    en = 1'b1; rst = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && period_start === 1'b0, "R11 mid", int'(out_valid), 0);
    rst = 1'b0; k = 0; lfsr = 7'h7F; last_byte = 8'h00;
    for (int c = 0; c < PER + 5; c++) run_cycle(1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule